// File: doc/BRIEF.md
# UART Receive Queue and Status Controller

This block sits between a serial receiver, which presents fully assembled bytes, and a processor register port. Accepted bytes go into a 16-entry first-in first-out queue. Reading the data register takes one byte off the head of the queue, and the number of bytes waiting can be read from a count register.

The block keeps five sticky status flags:
- a threshold flag, set while the queue holds at least the programmed trigger level;
- a data-ready flag;
- a framing-error flag;
- a break flag;
- an overrun flag.

The live level of the serial input line can also be read. Software clears a flag by reading it as 1 and then writing 0 to it. An interrupt pulse marks each rising edge of the threshold flag.

Software enables reception and picks a trigger level of 1, 4, 8 or 14 bytes through a control register. When reception is disabled, incoming bytes are ignored.

Top module: `uart_rxq_status`

## Requirements
- R1: After reset the queue is empty (count 0), all five flags are 0, reception is disabled and the trigger select is 00 (level 1). Register map on `reg_addr`: 0 = control, 1 = status, 2 = data, 3 = count.
- R2: A `rx_valid` strobe with reception enabled (control bit 0 = 1) appends `rx_byte` to the queue. With reception disabled the strobe changes neither the count nor any flag.
- R3: A read of address 2 returns the byte at the head of the queue and removes it, so bytes come out in arrival order. A read of address 2 while the queue is empty returns the byte most recently removed (0 if none has been removed yet) and leaves the count unchanged.
- R4: Address 3 returns the number of queued bytes in bits [4:0], with the upper bits 0.
- R5: Control bits [2:1] select the trigger level: 00 = 1, 01 = 4, 10 = 8, 11 = 14. Status bit 0 (threshold flag) sets in the cycle after the registered count is at or above the selected level.
- R6: `rx_irq` is high for exactly the one cycle in which status bit 0 has just changed from 0 to 1.
- R7: A status flag clears on a write to address 1 with a 0 in its bit only if that flag was read as 1 by an earlier read of address 1. A write of 0 without that read, or any write of 1, leaves the flag set. If the flag's set condition holds in the clearing cycle, the flag stays set.
- R8: A byte that arrives while the queue holds 16 bytes, with no data read in the same cycle, is discarded and sets status bit 4 (overrun). If a data read happens in the same cycle, the byte is accepted.
- R9: A byte that arrives with `rx_frame_err` high sets status bit 2 (framing error).
- R10: A byte of value 0x00 that arrives with `rx_frame_err` high while `rxd_level` is low sets status bit 3 (break).
- R11: Status bit 1 (data ready) sets when an accepted byte leaves the queue count below the trigger level.
- R12: Status bit 5 shows the current `rxd_level`, and status bits [7:6] read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: an assembled byte is present |
| rx_byte | input | 8 | Received byte |
| rx_frame_err | input | 1 | The byte had a bad stop bit |
| rxd_level | input | 1 | Live serial input line level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The hardest case to reach from the ports is a flag-clear write that lands in the same cycle as that flag's set condition. Getting there needs a status read to arm the clear first, and the queue must still be at or above the trigger level when the 0 is written. The stimulus fills the queue past the trigger, reads status, and then writes 0 before draining it. A second hard case is a byte arriving into a full queue in the same cycle as a data read. The stimulus fills all 16 entries and then drives a read and a receive strobe together. A behavioural queue model checks every cycle that the byte was accepted and that no overrun was recorded.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned REG_W     = 8;

  localparam int unsigned FLG_THR  = 0;
  localparam int unsigned FLG_DRDY = 1;
  localparam int unsigned FLG_FERR = 2;
  localparam int unsigned FLG_BRK  = 3;
  localparam int unsigned FLG_OVR  = 4;
  localparam int unsigned STS_LINE = 5;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_STAT = 2'd1,
    ADR_DATA = 2'd2,
    ADR_CNT  = 2'd3
  } rxq_addr_e;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_level = 1;
      2'b01:   trig_level = 4;
      2'b10:   trig_level = 8;
      default: trig_level = 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [7:0]    wdata_i,
  output logic          en_o,
  output logic [1:0]    sel_o,
  output logic [CW-1:0] trig_o
);
  import uart_rxq_pkg::*;

  logic       en_q, en_d;
  logic [1:0] sel_q, sel_d;

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (wr_i) begin
      en_d  = wdata_i[0];
      sel_d = wdata_i[2:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= 2'b00;
    end else begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  assign en_o   = en_q;
  assign sel_o  = sel_q;
  assign trig_o = CW'(trig_level(sel_q));

  a_r1_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> ($stable(en_q) && $stable(sel_q)))
    else $error("a_r1_ctrl_hold");

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push_i,
  input  logic [DW-1:0]               data_i,
  input  logic                        pop_i,
  output logic [DW-1:0]               data_o,
  output logic [$clog2(DEPTH+1)-1:0]  count_o,
  output logic                        full_o,
  output logic                        empty_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] last_q, last_d;
  logic          do_pop, do_push;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    last_d   = last_q;
    if (do_push) begin
      wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      last_d   = mem_q[rd_ptr_q];
    end
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      last_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
      last_q   <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_ptr_q] <= data_i;
    end
  end

  assign data_o  = empty_o ? last_q : mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH))
    else $error("a_r8_no_overflow");

  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && push_i) |-> pop_i)
    else $error("a_r8_no_push_when_full");

  a_r3_empty_read_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i) |=> (cnt_q == '0))
    else $error("a_r3_empty_read_keeps_count");

endmodule

// File: rtl/rxq_flag.sv
module rxq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_req_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr;

  always_comb begin
    clr    = clr_req_i && arm_q && !set_i;
    flag_d = set_i || (flag_q && !clr);
    if (clr) begin
      arm_d = 1'b0;
    end else if (rd_i) begin
      arm_d = flag_q;
    end else begin
      arm_d = arm_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;

  a_r7_fall_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(arm_q))
    else $error("a_r7_fall_needs_arm");

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_q)
    else $error("a_r7_set_wins");

  a_r7_no_clear_without_request: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_req_i) |=> flag_q)
    else $error("a_r7_no_clear_without_request");

endmodule

// File: rtl/uart_rxq_status.sv
module uart_rxq_status #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_frame_err,
  input  logic          rxd_level,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          rx_irq
);
  import uart_rxq_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH+1);

  logic          en, fifo_full, fifo_empty;
  logic [1:0]    sel;
  logic [CW-1:0] trig, count;
  logic [DW-1:0] head;
  logic          rd_data, rd_stat, wr_ctrl, wr_stat;
  logic          pop_eff, byte_in, accept;
  logic [CW:0]   cnt_after;
  logic [NUM_FLAGS-1:0] set_v, clr_v, flags;
  logic          thr_prev_q;

  assign rd_data = reg_rd && (reg_addr == ADR_DATA);
  assign rd_stat = reg_rd && (reg_addr == ADR_STAT);
  assign wr_ctrl = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_stat = reg_wr && (reg_addr == ADR_STAT);

  rxq_ctrl #(.CW(CW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_ctrl),
    .wdata_i(reg_wdata),
    .en_o   (en),
    .sel_o  (sel),
    .trig_o (trig)
  );

  assign pop_eff   = rd_data && !fifo_empty;
  assign byte_in   = rx_valid && en;
  assign accept    = byte_in && (!fifo_full || pop_eff);
  assign cnt_after = {1'b0, count} + (CW+1)'(accept) - (CW+1)'(pop_eff);

  rxq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (accept),
    .data_i (rx_byte),
    .pop_i  (rd_data),
    .data_o (head),
    .count_o(count),
    .full_o (fifo_full),
    .empty_o(fifo_empty)
  );

  always_comb begin
    set_v           = '0;
    set_v[FLG_THR]  = (count >= trig);
    set_v[FLG_DRDY] = accept && (cnt_after < {1'b0, trig});
    set_v[FLG_FERR] = byte_in && rx_frame_err;
    set_v[FLG_BRK]  = byte_in && rx_frame_err && (rx_byte == '0) && !rxd_level;
    set_v[FLG_OVR]  = byte_in && !accept;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      assign clr_v[gi] = wr_stat && !reg_wdata[gi];
      rxq_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_v[gi]),
        .rd_i     (rd_stat),
        .clr_req_i(clr_v[gi]),
        .flag_o   (flags[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_prev_q <= 1'b0;
    end else begin
      thr_prev_q <= flags[FLG_THR];
    end
  end

  assign rx_irq = flags[FLG_THR] && !thr_prev_q;

  always_comb begin
    case (reg_addr)
      ADR_CTRL: reg_rdata = {5'b0, sel, en};
      ADR_STAT: reg_rdata = {2'b0, rxd_level, flags};
      ADR_DATA: reg_rdata = REG_W'(head);
      default:  reg_rdata = REG_W'(count);
    endcase
  end

  a_r2_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !pop_eff) |=> $stable(count))
    else $error("a_r2_disabled_hold");

  a_r8_drop_sets_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && fifo_full && !rd_data) |=> (flags[FLG_OVR] && $stable(count)))
    else $error("a_r8_drop_sets_ovr");

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq)
    else $error("a_r6_irq_single");

  a_r5_thr_follows_count: assert property (@(posedge clk) disable iff (!rst_n)
    (count >= trig) |=> flags[FLG_THR])
    else $error("a_r5_thr_follows_count");

endmodule

// File: tb/tb_uart_rxq_status.sv
module tb_uart_rxq_status;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rx_frame_err, rxd_level, reg_wr, reg_rd;
  logic [7:0] rx_byte, reg_wdata, reg_rdata;
  logic [1:0] reg_addr;
  logic       rx_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  uart_rxq_status dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_frame_err(rx_frame_err), .rxd_level(rxd_level), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rx_irq(rx_irq)
  );

  // behavioural reference state
  byte unsigned q[$];
  bit [7:0] m_last;
  bit [4:0] m_flag, m_arm;
  bit       m_prev, m_en;
  bit [1:0] m_sel;

  function automatic int lvl(input bit [1:0] s);
    case (s)
      2'b00: return 1;
      2'b01: return 4;
      2'b10: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic bit [7:0] exp_rdata();
    case (reg_addr)
      2'd0: return {5'b0, m_sel, m_en};
      2'd1: return {2'b0, rxd_level, m_flag};
      2'd2: return (q.size() > 0) ? q[0] : m_last;
      default: return 8'(q.size());
    endcase
  endfunction

  task automatic model_tick();
    int sz = q.size();
    bit popm = reg_rd && reg_addr == 2'd2 && sz > 0;
    bit bin  = rx_valid && m_en;
    bit acc  = bin && (sz < 16 || popm);
    int after = sz + int'(acc) - int'(popm);
    bit [4:0] st;
    st[0] = sz >= lvl(m_sel);
    st[1] = acc && after < lvl(m_sel);
    st[2] = bin && rx_frame_err;
    st[3] = bin && rx_frame_err && rx_byte == 8'h00 && !rxd_level;
    st[4] = bin && !acc;
    m_prev = m_flag[0];
    for (int i = 0; i < 5; i++) begin
      bit clr = reg_wr && reg_addr == 2'd1 && !reg_wdata[i] && m_arm[i] && !st[i];
      bit na  = clr ? 1'b0 : ((reg_rd && reg_addr == 2'd1) ? m_flag[i] : m_arm[i]);
      m_flag[i] = st[i] | (m_flag[i] & !clr);
      m_arm[i]  = na;
    end
    if (popm) m_last = q.pop_front();
    if (acc) q.push_back(rx_byte);
    if (reg_wr && reg_addr == 2'd0) begin
      m_en  = reg_wdata[0];
      m_sel = reg_wdata[2:1];
    end
  endtask

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // one clock: compare outputs, let the edge pass, update the model
  task automatic cycle(input string tag);
    #1;
    check(tag, reg_rdata, exp_rdata(), "reg_rdata");
    check(tag, rx_irq, int'(m_flag[0] && !m_prev), "rx_irq");
    @(posedge clk);
    model_tick();
    @(negedge clk);
    rx_valid = 0; rx_frame_err = 0; reg_wr = 0; reg_rd = 0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cycle(tag);
  endtask

  task automatic send(input bit [7:0] b, input bit fe, input string tag);
    rx_valid = 1; rx_byte = b; rx_frame_err = fe;
    cycle(tag);
  endtask

  task automatic rd(input bit [1:0] a, input string tag);
    reg_rd = 1; reg_addr = a;
    cycle(tag);
  endtask

  task automatic wr(input bit [1:0] a, input bit [7:0] d, input string tag);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cycle(tag);
  endtask

  task automatic send_pop(input bit [7:0] b, input string tag);
    rx_valid = 1; rx_byte = b; rx_frame_err = 0;
    reg_rd = 1; reg_addr = 2'd2;
    cycle(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_valid = 0; rx_byte = 0; rx_frame_err = 0; rxd_level = 1;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    m_last = 0; m_flag = 0; m_arm = 0; m_prev = 0; m_en = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state at every address
    for (int a = 0; a < 4; a++) rd(2'(a), "R1");
    // R2: disabled receiver ignores bytes
    send(8'h55, 1, "R2");
    rd(2'd3, "R2"); rd(2'd1, "R2");
    // enable, trigger 4
    wr(2'd0, 8'h03, "R5");
    reg_addr = 2'd1;
    send(8'h11, 0, "R11"); send(8'h22, 0, "R11"); send(8'h33, 0, "R11");
    rd(2'd3, "R4");
    reg_addr = 2'd1;
    send(8'h44, 0, "R5");
    idle(3, "R6");
    // R7: write 0 without prior read leaves flags set
    wr(2'd1, 8'h00, "R7");
    rd(2'd1, "R7");
    wr(2'd1, 8'hFF, "R7");        // write 1 has no effect
    wr(2'd1, 8'h00, "R7");        // threshold still met: stays set; drdy clears
    rd(2'd1, "R7");
    rd(2'd2, "R3"); rd(2'd2, "R3"); rd(2'd2, "R3");
    rd(2'd1, "R7"); wr(2'd1, 8'h00, "R7"); rd(2'd1, "R7");
    rd(2'd2, "R3"); rd(2'd2, "R3"); rd(2'd2, "R3"); rd(2'd3, "R3");
    // trigger 14, fill to overrun
    wr(2'd0, 8'h07, "R5");
    reg_addr = 2'd3;
    for (int i = 0; i < 17; i++) send(8'(8'hA0 + i), 0, "R8");
    rd(2'd3, "R8"); rd(2'd1, "R8");
    // simultaneous pop and arrival into a full queue
    wr(2'd1, 8'h00, "R8");
    send_pop(8'hEE, "R8");
    rd(2'd3, "R8"); rd(2'd1, "R8");
    // drain
    for (int i = 0; i < 17; i++) rd(2'd2, "R3");
    rd(2'd1, "R5");
    wr(2'd1, 8'h00, "R7"); rd(2'd1, "R7");
    // framing error, break, live line level
    wr(2'd0, 8'h05, "R5");
    reg_addr = 2'd1;
    send(8'h5A, 1, "R9");
    rxd_level = 0;
    send(8'h00, 1, "R10");
    rd(2'd1, "R12");
    rxd_level = 1;
    rd(2'd1, "R12");
    for (int i = 0; i < 7; i++) send(8'(i), 0, "R5");
    idle(2, "R6");
    rd(2'd3, "R4");
    // trigger 1: single byte raises threshold
    for (int i = 0; i < 10; i++) rd(2'd2, "R3");
    rd(2'd1, "R7"); wr(2'd1, 8'h00, "R7");
    wr(2'd0, 8'h01, "R5");
    reg_addr = 2'd1;
    send(8'h99, 0, "R5");
    idle(2, "R6");
    // disable again: bytes ignored
    wr(2'd0, 8'h00, "R2");
    send(8'h77, 1, "R2");
    rd(2'd3, "R2"); rd(2'd1, "R2"); rd(2'd2, "R3"); rd(2'd2, "R3");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule